// File: doc/BRIEF.md
# Serial Flash Lane-Width Protocol Selector

This block sits inside the slave side of a serial NOR flash and decides how many data lines each part of a transaction uses. It tracks one of three protocols: extended, dual and quad. For the current transaction it gives a lane-width code for the opcode phase, the address phase and the data phase. The opcode decoder, the bit shifter and the memory array are outside the block. The decoder tells the block when a volatile configuration write or a nonvolatile configuration write has completed. A separate power-on pulse reloads the protocol from the nonvolatile bits. A rescue pulse forces the extended protocol.

Volatile selections act right after the write, but never in the middle of a transaction. Nonvolatile selections act only at the next power-on, and they stay in force across every later power-on. When a program or erase runs with the high-voltage pin driven, quad operation drops to the extended protocol until the pin is released. This lets the host suspend the operation or poll status on a single line.

The mode inputs carry only the two bits that matter. `vol_sel_i[1]` is volatile configuration bit 7 and `vol_sel_i[0]` is bit 6. `nv_sel_i[1]` is nonvolatile configuration bit 3 and `nv_sel_i[0]` is bit 2.

Top module: `flash_lane_sel`

## Requirements
- R1: After rst_ni the block is in extended protocol (proto_o = 0) and the stored nonvolatile bits are 2'b11.
- R2: In extended protocol, cmd_w_o = 0 (one line), addr_w_o follows ext_addr_w_i and data_w_o follows ext_data_w_i. An input code of 3 is reported as 0. Lane codes are 0 = one line, 1 = two lines, 2 = four lines.
- R3: In dual protocol (proto_o = 1) all three lane outputs are 1. In quad protocol (proto_o = 2) all three are 2.
- R4: A volatile write with vol_sel_i[1] = 0 selects quad, whatever the value of vol_sel_i[0].
- R5: A volatile write with vol_sel_i = 2'b10 selects dual. A write with 2'b11 selects extended.
- R6: A nonvolatile write does not change proto_o. On por_i the protocol becomes quad if nv_sel[1] = 0, otherwise dual if nv_sel[0] = 0, otherwise extended.
- R7: The stored nonvolatile bits persist across any number of por_i pulses until they are rewritten. por_i discards any earlier volatile selection.
- R8: A rescue_i pulse selects extended protocol.
- R9: A pending selection reaches proto_o one cycle after it is made, and only on a cycle in which cs_n_i is high. While cs_n_i stays low, proto_o holds, except that por_i applies its mode on the next cycle.
- R10: While the selected protocol is quad and hv_busy_i was high on the last cycle with cs_n_i high, proto_o is extended. Quad returns once hv_busy_i is seen low with cs_n_i high. hv_busy_i has no effect in dual or extended.
- R11: When events arrive in the same cycle, por_i wins over rescue_i, and rescue_i wins over a volatile write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on event pulse |
| cs_n_i | input | 1 | Chip select, active low |
| rescue_i | input | 1 | Rescue sequence detected, pulse |
| vol_wr_i | input | 1 | Volatile configuration write completed, pulse |
| vol_sel_i | input | 2 | Volatile bits {bit7, bit6} |
| nv_wr_i | input | 1 | Nonvolatile configuration write completed, pulse |
| nv_sel_i | input | 2 | Nonvolatile bits {bit3, bit2} |
| hv_busy_i | input | 1 | Program/erase running with the high-voltage pin driven |
| ext_addr_w_i | input | 2 | Opcode address-phase width in extended protocol |
| ext_data_w_i | input | 2 | Opcode data-phase width in extended protocol |
| proto_o | output | 2 | 0 = extended, 1 = dual, 2 = quad |
| cmd_w_o | output | 2 | Opcode-phase lane code |
| addr_w_o | output | 2 | Address-phase lane code |
| data_w_o | output | 2 | Data-phase lane code |

## Verification
The hardest situation to reach is the overlap of several conditions. A selection is pending while chip select is low, a high-voltage operation starts or ends inside that same transaction, and a power-on or rescue lands in the same cycle as a configuration write. Directed sequences hold chip select low across volatile writes and high-voltage changes, then release it and check that the new mode shows up one cycle later. A randomised phase drives all event pulses together at independent rates. A cycle-level reference model built from the requirements predicts every output.

// File: rtl/flash_lane_pkg.sv
package flash_lane_pkg;
  localparam int unsigned LANE_W = 2;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic [1:0] {
    PROTO_EXT  = 2'd0,
    PROTO_DUAL = 2'd1,
    PROTO_QUAD = 2'd2
  } proto_e;

  localparam logic [LANE_W-1:0] LANE_X1 = 2'd0;
  localparam logic [LANE_W-1:0] LANE_X2 = 2'd1;
  localparam logic [LANE_W-1:0] LANE_X4 = 2'd2;

  // sel[1]: quad enable (active low), sel[0]: dual enable (active low)
  function automatic proto_e sel_decode(logic [SEL_W-1:0] sel);
    if (!sel[1])      return PROTO_QUAD;
    else if (!sel[0]) return PROTO_DUAL;
    else              return PROTO_EXT;
  endfunction

  function automatic logic [LANE_W-1:0] lane_clamp(logic [LANE_W-1:0] w);
    return (w > LANE_X4) ? LANE_X1 : w;
  endfunction
endpackage

// File: rtl/flash_lane_cfg.sv
module flash_lane_cfg
  import flash_lane_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_i,
  input  logic             rescue_i,
  input  logic             vol_wr_i,
  input  logic [SEL_W-1:0] vol_sel_i,
  input  logic             nv_wr_i,
  input  logic [SEL_W-1:0] nv_sel_i,
  output proto_e           tgt_o,
  output proto_e           boot_o
);
  logic [SEL_W-1:0] nv_q;
  proto_e           tgt_q;

  assign boot_o = sel_decode(nv_q);
  assign tgt_o  = tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nv_q <= '1;
    end else if (nv_wr_i) begin
      nv_q <= nv_sel_i;
    end
  end

  // por beats rescue beats volatile write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= PROTO_EXT;
    end else if (por_i) begin
      tgt_q <= boot_o;
    end else if (rescue_i) begin
      tgt_q <= PROTO_EXT;
    end else if (vol_wr_i) begin
      tgt_q <= sel_decode(vol_sel_i);
    end
  end
endmodule

// File: rtl/flash_lane_apply.sv
module flash_lane_apply
  import flash_lane_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   por_i,
  input  logic   cs_n_i,
  input  logic   hv_busy_i,
  input  proto_e tgt_i,
  input  proto_e boot_i,
  output proto_e proto_o
);
  proto_e act_q;
  logic   hv_q;

  // mode and high-voltage state only move between transactions
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= PROTO_EXT;
      hv_q  <= 1'b0;
    end else begin
      if (por_i)       act_q <= boot_i;
      else if (cs_n_i) act_q <= tgt_i;
      if (cs_n_i)      hv_q  <= hv_busy_i;
    end
  end

  assign proto_o = (act_q == PROTO_QUAD && hv_q) ? PROTO_EXT : act_q;
endmodule

// File: rtl/flash_lane_map.sv
module flash_lane_map
  import flash_lane_pkg::*;
(
  input  proto_e              proto_i,
  input  logic [LANE_W-1:0]   ext_addr_w_i,
  input  logic [LANE_W-1:0]   ext_data_w_i,
  output logic [LANE_W-1:0]   cmd_w_o,
  output logic [LANE_W-1:0]   addr_w_o,
  output logic [LANE_W-1:0]   data_w_o
);
  always_comb begin
    unique case (proto_i)
      PROTO_DUAL: begin
        cmd_w_o  = LANE_X2;
        addr_w_o = LANE_X2;
        data_w_o = LANE_X2;
      end
      PROTO_QUAD: begin
        cmd_w_o  = LANE_X4;
        addr_w_o = LANE_X4;
        data_w_o = LANE_X4;
      end
      default: begin
        cmd_w_o  = LANE_X1;
        addr_w_o = lane_clamp(ext_addr_w_i);
        data_w_o = lane_clamp(ext_data_w_i);
      end
    endcase
  end
endmodule

// File: rtl/flash_lane_sel.sv
module flash_lane_sel
  import flash_lane_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_i,
  input  logic       cs_n_i,
  input  logic       rescue_i,
  input  logic       vol_wr_i,
  input  logic [1:0] vol_sel_i,
  input  logic       nv_wr_i,
  input  logic [1:0] nv_sel_i,
  input  logic       hv_busy_i,
  input  logic [1:0] ext_addr_w_i,
  input  logic [1:0] ext_data_w_i,
  output logic [1:0] proto_o,
  output logic [1:0] cmd_w_o,
  output logic [1:0] addr_w_o,
  output logic [1:0] data_w_o
);
  proto_e tgt, boot, proto;

  flash_lane_cfg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .por_i     (por_i),
    .rescue_i  (rescue_i),
    .vol_wr_i  (vol_wr_i),
    .vol_sel_i (vol_sel_i),
    .nv_wr_i   (nv_wr_i),
    .nv_sel_i  (nv_sel_i),
    .tgt_o     (tgt),
    .boot_o    (boot)
  );

  flash_lane_apply u_apply (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .por_i     (por_i),
    .cs_n_i    (cs_n_i),
    .hv_busy_i (hv_busy_i),
    .tgt_i     (tgt),
    .boot_i    (boot),
    .proto_o   (proto)
  );

  flash_lane_map u_map (
    .proto_i      (proto),
    .ext_addr_w_i (ext_addr_w_i),
    .ext_data_w_i (ext_data_w_i),
    .cmd_w_o      (cmd_w_o),
    .addr_w_o     (addr_w_o),
    .data_w_o     (data_w_o)
  );

  assign proto_o = proto;
endmodule

// File: rtl/flash_lane_sel_chk.sv
module flash_lane_sel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_i,
  input logic       cs_n_i,
  input logic       rescue_i,
  input logic       hv_busy_i,
  input logic [1:0] proto_o,
  input logic [1:0] cmd_w_o,
  input logic [1:0] addr_w_o,
  input logic [1:0] data_w_o
);
  a_r2_ext_cmd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_o == 2'd0 |-> cmd_w_o == 2'd0);

  a_r3_dual_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_o == 2'd1 |-> (cmd_w_o == 2'd1 && addr_w_o == 2'd1 && data_w_o == 2'd1));

  a_r3_quad_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_o == 2'd2 |-> (cmd_w_o == 2'd2 && addr_w_o == 2'd2 && data_w_o == 2'd2));

  a_r9_hold_in_txn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cs_n_i) && !$past(por_i)) |-> $stable(proto_o));

  a_r10_hv_no_quad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cs_n_i) && $past(hv_busy_i)) |-> proto_o != 2'd2);

  a_r8_rescue_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rescue_i, 2) && !$past(por_i, 2) && $past(cs_n_i) && !$past(por_i))
      |-> proto_o == 2'd0);

  a_r3_proto_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_o != 2'd3);
endmodule

bind flash_lane_sel flash_lane_sel_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .por_i     (por_i),
  .cs_n_i    (cs_n_i),
  .rescue_i  (rescue_i),
  .hv_busy_i (hv_busy_i),
  .proto_o   (proto_o),
  .cmd_w_o   (cmd_w_o),
  .addr_w_o  (addr_w_o),
  .data_w_o  (data_w_o)
);

// File: tb/flash_lane_sel_tb.sv
module flash_lane_sel_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       por = 1'b0, cs_n = 1'b1, rescue = 1'b0, vwr = 1'b0, nwr = 1'b0, hv = 1'b0;
  logic [1:0] vsel = 2'b11, nsel = 2'b11, ea = 2'd0, ed = 2'd0;
  logic [1:0] proto, cmd_w, addr_w, data_w;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [1:0] m_nv = 2'b11, m_tgt = 2'd0, m_act = 2'd0;
  logic       m_hv = 1'b0;

  always #2 clk = ~clk;

  flash_lane_sel u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .por_i(por), .cs_n_i(cs_n), .rescue_i(rescue),
    .vol_wr_i(vwr), .vol_sel_i(vsel), .nv_wr_i(nwr), .nv_sel_i(nsel), .hv_busy_i(hv),
    .ext_addr_w_i(ea), .ext_data_w_i(ed),
    .proto_o(proto), .cmd_w_o(cmd_w), .addr_w_o(addr_w), .data_w_o(data_w)
  );

  function automatic logic [1:0] dec(logic [1:0] s);
    return !s[1] ? 2'd2 : (!s[0] ? 2'd1 : 2'd0);
  endfunction

  function automatic logic [1:0] clampw(logic [1:0] w);
    return (w == 2'd3) ? 2'd0 : w;
  endfunction

  function automatic logic [1:0] exp_proto();
    return (m_act == 2'd2 && m_hv) ? 2'd0 : m_act;
  endfunction

  task automatic check(string tag, string what, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    logic [1:0] p;
    p = exp_proto();
    check(tag, "proto", proto, p);
    check(tag, "cmd_w", cmd_w, (p == 2'd0) ? 2'd0 : p);
    check(tag, "addr_w", addr_w, (p == 2'd0) ? clampw(ea) : p);
    check(tag, "data_w", data_w, (p == 2'd0) ? clampw(ed) : p);
  endtask

  task automatic cyc(string tag, logic c, logic po, logic rs, logic vw, logic [1:0] vs,
                     logic nw, logic [1:0] ns, logic h, logic [1:0] a, logic [1:0] d);
    logic [1:0] boot;
    @(negedge clk);
    cs_n = c; por = po; rescue = rs; vwr = vw; vsel = vs; nwr = nw; nsel = ns;
    hv = h; ea = a; ed = d;
    @(posedge clk);
    boot = dec(m_nv);
    if (po)     m_act = boot;
    else if (c) m_act = m_tgt;
    if (c)      m_hv = h;
    if (po)      m_tgt = boot;
    else if (rs) m_tgt = 2'd0;
    else if (vw) m_tgt = dec(vs);
    if (nw) m_nv = ns;
    #1;
    compare(tag);
  endtask

  // shorthand: idle cycle with chip select state and hv level
  task automatic idle(string tag, logic c, logic h, int n);
    for (int i = 0; i < n; i++) cyc(tag, c, 0, 0, 0, 2'b11, 0, 2'b11, h, ea, ed);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    ea = 2'd2; ed = 2'd1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    #1;
    compare("R1");

    // R2: extended widths, code 3 clamps
    cyc("R2", 1, 0, 0, 0, 2'b11, 0, 2'b11, 0, 2'd3, 2'd2);
    cyc("R2", 1, 0, 0, 0, 2'b11, 0, 2'b11, 0, 2'd1, 2'd3);

    // R4: bit7 low selects quad regardless of bit6
    cyc("R4", 1, 0, 0, 1, 2'b01, 0, 2'b11, 0, ea, ed);
    idle("R4", 1, 0, 2);
    cyc("R4", 1, 0, 0, 1, 2'b11, 0, 2'b11, 0, ea, ed);
    idle("R5", 1, 0, 2);
    cyc("R4", 1, 0, 0, 1, 2'b00, 0, 2'b11, 0, ea, ed);
    idle("R3", 1, 0, 2);

    // R5: dual and back to extended
    cyc("R5", 1, 0, 0, 1, 2'b10, 0, 2'b11, 0, ea, ed);
    idle("R5", 1, 0, 2);
    cyc("R5", 1, 0, 0, 1, 2'b11, 0, 2'b11, 0, ea, ed);
    idle("R5", 1, 0, 2);

    // R9: selection inside a transaction waits for cs high
    cyc("R9", 0, 0, 0, 1, 2'b01, 0, 2'b11, 0, ea, ed);
    idle("R9", 0, 0, 4);
    idle("R9", 1, 0, 2);

    // R10: quad falls back under hv, also hv change mid-transaction is deferred
    idle("R10", 1, 1, 2);
    idle("R10", 0, 0, 3);
    idle("R10", 1, 0, 2);
    cyc("R10", 1, 0, 0, 1, 2'b10, 0, 2'b11, 1, ea, ed);
    idle("R10", 1, 1, 3);
    idle("R10", 1, 0, 1);

    // R8: rescue
    cyc("R8", 1, 0, 0, 1, 2'b00, 0, 2'b11, 0, ea, ed);
    idle("R8", 1, 0, 2);
    cyc("R8", 1, 0, 1, 0, 2'b11, 0, 2'b11, 0, ea, ed);
    idle("R8", 1, 0, 2);

    // R6: nonvolatile write has no immediate effect
    cyc("R6", 1, 0, 0, 0, 2'b11, 1, 2'b10, 0, ea, ed);
    idle("R6", 1, 0, 3);
    cyc("R6", 0, 1, 0, 0, 2'b11, 0, 2'b11, 0, ea, ed);
    idle("R6", 1, 0, 2);
    cyc("R6", 1, 0, 0, 0, 2'b11, 1, 2'b00, 0, ea, ed);
    idle("R6", 1, 0, 2);
    cyc("R6", 1, 1, 0, 0, 2'b11, 0, 2'b11, 0, ea, ed);
    idle("R6", 1, 0, 2);

    // R7: volatile override lost at power-on, nv persists
    cyc("R7", 1, 0, 0, 1, 2'b11, 0, 2'b11, 0, ea, ed);
    idle("R7", 1, 0, 2);
    cyc("R7", 1, 1, 0, 0, 2'b11, 0, 2'b11, 0, ea, ed);
    idle("R7", 1, 0, 2);
    cyc("R7", 1, 1, 0, 0, 2'b11, 0, 2'b11, 0, ea, ed);
    idle("R7", 1, 0, 1);
    cyc("R7", 1, 0, 0, 0, 2'b11, 1, 2'b11, 0, ea, ed);
    cyc("R7", 1, 1, 0, 0, 2'b11, 0, 2'b11, 0, ea, ed);
    idle("R7", 1, 0, 2);

    // R11: simultaneous events
    cyc("R11", 1, 0, 0, 0, 2'b11, 1, 2'b10, 0, ea, ed);
    cyc("R11", 1, 1, 1, 1, 2'b00, 0, 2'b11, 0, ea, ed);
    idle("R11", 1, 0, 2);
    cyc("R11", 1, 0, 1, 1, 2'b00, 0, 2'b11, 0, ea, ed);
    idle("R11", 1, 0, 2);

    // random mix
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 2000; i++) begin
      logic c, po, rs, vw, nw, h;
      logic [1:0] vs, ns, a, d;
      string tag;
      c  = ($urandom % 4) != 0;
      po = ($urandom % 40) == 0;
      rs = ($urandom % 25) == 0;
      vw = ($urandom % 7) == 0;
      nw = ($urandom % 12) == 0;
      h  = ($urandom % 3) == 0;
      vs = 2'($urandom); ns = 2'($urandom);
      a  = 2'($urandom); d  = 2'($urandom);
      tag = po ? "R6" : (!c ? "R9" : (h ? "R10" : (vw ? "R4" : "R3")));
      cyc(tag, c, po, rs, vw, vs, nw, ns, h, a, d);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule